// File: doc/BRIEF.md
# Store Queue with Writeback Pointer

This block holds the stores of one thread in a circular buffer from the moment they are dispatched until the memory side confirms that they are written. A store takes the tail slot at dispatch, carrying only its age tag. When the store executes, its address, access size and data are written into that slot. A commit naming an age tag marks every store at or older than that tag as eligible for writeback.

A separate writeback pointer walks the eligible stores in program order and offers them to a memory request port, one per cycle. If the port refuses, the store path blocks and sends nothing until a retry pulse arrives; the same store is then offered again. A store is freed only once its completion acknowledge has come back. Acknowledges may arrive in any order, and the head retires completed stores one per cycle while they are contiguous. A squash drops the uncommitted stores younger than a given tag and rewinds the tail. Age tags grow with program order, so a smaller tag means an older store.

Top module: `stq_store_queue`

## Requirements
- R1: After reset the occupancy and the pending-writeback count read zero, full is low and no memory request is offered.
- R2: A store is accepted when ins_valid is high, full is low and no squash is present. It takes the slot shown on ins_idx, and ins_idx then moves to the next slot, wrapping from SLOTS-1 to 0.
- R3: One slot is always kept empty. full is high when the occupancy is at least SLOTS-1, and an insert offered while full changes nothing.
- R4: A newly inserted store has size zero and no flags set. If it is committed before its data-write, it is offered to memory with mreq_size equal to 0.
- R5: A data-write to an occupied slot sets that slot's address, size and data, and these values appear on mreq_addr, mreq_size and mreq_data when the slot is offered. A data-write to an empty slot is ignored.
- R6: A commit with tag T marks every occupied, not yet committed store whose tag is at most T. wb_pending rises by the number of stores newly marked, so committing a store a second time adds nothing.
- R7: mreq_valid is high only when the slot at the writeback pointer is committed, not completed and not yet offered, and the store path is not blocked. Stores are offered one per cycle in slot order.
- R8: A cycle with mreq_valid high and mreq_ready low blocks the store path. mreq_valid stays low until an mretry pulse, and after the pulse the same slot, address and data are offered again.
- R9: Commit and acceptance by memory do not lower the occupancy. An acknowledge on mack_idx marks that slot completed, and the head then releases completed slots one per cycle, stopping at the first slot that is not completed, whatever order the acknowledges came in.
- R10: A squash with tag T removes every uncommitted store whose tag is greater than T. Committed stores are kept, the occupancy drops by the number removed, ins_idx rewinds to the first removed slot, and an insert in the same cycle is ignored.
- R11: wb_pending drops by one for every request accepted by memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert a new store at the tail |
| ins_tag | input | TAGW | Age tag of the new store |
| ins_idx | output | IDXW | Slot the next insert will take (tail) |
| dw_valid | input | 1 | Data-write strobe |
| dw_idx | input | IDXW | Slot to write |
| dw_addr | input | AW | Store address |
| dw_size | input | SZW | Access size in bytes |
| dw_data | input | DW | Store data |
| cm_valid | input | 1 | Commit strobe |
| cm_tag | input | TAGW | Youngest tag committed |
| sq_valid | input | 1 | Squash strobe |
| sq_tag | input | TAGW | Youngest tag that survives the squash |
| mreq_valid | output | 1 | Store offered to memory |
| mreq_ready | input | 1 | Memory accepts the offered store |
| mreq_idx | output | IDXW | Slot of the offered store |
| mreq_addr | output | AW | Address of the offered store |
| mreq_size | output | SZW | Size of the offered store |
| mreq_data | output | DW | Data of the offered store |
| mretry | input | 1 | Memory can take the refused store again |
| mack_valid | input | 1 | Write completion acknowledge |
| mack_idx | input | IDXW | Slot whose write completed |
| occ | output | CNTW | Stores held |
| full | output | 1 | Queue full |
| wb_pending | output | CNTW | Committed stores not yet accepted by memory |

## Verification
The properties assume that tags grow in the order stores are inserted, that each slot is acknowledged once and only after memory has accepted it, and that commit and squash tags refer to stores already dispatched. The bench hands out tags from a rising counter and picks each acknowledge at random from the slots its own model records as accepted but not yet completed. Commit and squash tags are drawn a few steps below the newest tag. Refusals and retries come from random ready and retry levels, so blocking happens at varied depths of the queue.

// File: rtl/stq_pkg.sv
package stq_pkg;

  // Circular step: move base forward by up and back by down (down < slots).
  function automatic int ring_add(input int base, input int up, input int down, input int slots);
    return (base + up + slots - down) % slots;
  endfunction

  // Number of forward steps from a to b in a ring of the given size.
  function automatic int ring_dist(input int a, input int b, input int slots);
    return (b + slots - a) % slots;
  endfunction

endpackage

// File: rtl/stq_entries.sv
module stq_entries #(
  parameter int SLOTS = 8,
  parameter int IDXW  = 3,
  parameter int TAGW  = 16,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int SZW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] occ_mask,
  input  logic             ins_en,
  input  logic [IDXW-1:0]  tail_idx,
  input  logic [TAGW-1:0]  ins_tag,
  input  logic             dw_valid,
  input  logic [IDXW-1:0]  dw_idx,
  input  logic [AW-1:0]    dw_addr,
  input  logic [SZW-1:0]   dw_size,
  input  logic [DW-1:0]    dw_data,
  input  logic             cm_valid,
  input  logic [TAGW-1:0]  cm_tag,
  input  logic             sq_valid,
  input  logic [TAGW-1:0]  sq_tag,
  input  logic             ack_valid,
  input  logic [IDXW-1:0]  ack_idx,
  input  logic [IDXW-1:0]  rd_idx,
  output logic [AW-1:0]    rd_addr,
  output logic [SZW-1:0]   rd_size,
  output logic [DW-1:0]    rd_data,
  output logic [SLOTS-1:0] cwb_v,
  output logic [SLOTS-1:0] cmp_v,
  output logic [SLOTS-1:0] newc_mask,
  output logic [SLOTS-1:0] kill_mask
);

  logic [AW-1:0]  addr_a [SLOTS];
  logic [SZW-1:0] size_a [SLOTS];
  logic [DW-1:0]  data_a [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [TAGW-1:0] tag_q, tag_d;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   data_q;
    logic [SZW-1:0]  size_q, size_d;
    logic            cwb_q, cwb_d, cmt_q, cmt_d, cmp_q, cmp_d;
    logic            ins_hit, dw_hit, ack_hit, cm_hit, kill_hit;

    assign ins_hit  = ins_en && (tail_idx == IDXW'(i));
    assign dw_hit   = dw_valid && occ_mask[i] && (dw_idx == IDXW'(i));
    assign ack_hit  = ack_valid && occ_mask[i] && (ack_idx == IDXW'(i));
    assign cm_hit   = cm_valid && occ_mask[i] && !cmt_q && (tag_q <= cm_tag);
    assign kill_hit = sq_valid && occ_mask[i] && !cmt_q && !cm_hit && (tag_q > sq_tag);

    always_comb begin
      tag_d  = tag_q;
      size_d = size_q;
      cwb_d  = cwb_q;
      cmt_d  = cmt_q;
      cmp_d  = cmp_q;
      if (ins_hit) begin
        tag_d  = ins_tag;
        size_d = '0;
        cwb_d  = 1'b0;
        cmt_d  = 1'b0;
        cmp_d  = 1'b0;
      end else begin
        if (dw_hit) begin
          size_d = dw_size;
        end
        if (cm_hit) begin
          cwb_d = 1'b1;
          cmt_d = 1'b1;
        end
        if (ack_hit) begin
          cmp_d = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q  <= '0;
        size_q <= '0;
        cwb_q  <= 1'b0;
        cmt_q  <= 1'b0;
        cmp_q  <= 1'b0;
      end else begin
        tag_q  <= tag_d;
        size_q <= size_d;
        cwb_q  <= cwb_d;
        cmt_q  <= cmt_d;
        cmp_q  <= cmp_d;
      end
    end

    // Datapath fields carry no reset; they are loaded only by a data-write.
    always_ff @(posedge clk) begin
      if (dw_hit) begin
        addr_q <= dw_addr;
        data_q <= dw_data;
      end
    end

    assign addr_a[i]    = addr_q;
    assign size_a[i]    = size_q;
    assign data_a[i]    = data_q;
    assign cwb_v[i]     = cwb_q;
    assign cmp_v[i]     = cmp_q;
    assign newc_mask[i] = cm_hit;
    assign kill_mask[i] = kill_hit;
  end

  assign rd_addr = addr_a[rd_idx];
  assign rd_size = size_a[rd_idx];
  assign rd_data = data_a[rd_idx];

endmodule

// File: rtl/stq_ptrs.sv
module stq_ptrs #(
  parameter int SLOTS = 8,
  parameter int IDXW  = 3,
  parameter int CNTW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_ok,
  input  logic            retire,
  input  logic            wb_adv,
  input  logic [CNTW-1:0] kill_cnt,
  output logic [IDXW-1:0] head_q,
  output logic [IDXW-1:0] wb_q,
  output logic [IDXW-1:0] tail_q,
  output logic [CNTW-1:0] occ_q
);

  logic [IDXW-1:0] head_d, wb_d, tail_d;
  logic [CNTW-1:0] occ_d;

  always_comb begin
    head_d = retire ? IDXW'(stq_pkg::ring_add(int'(head_q), 1, 0, SLOTS)) : head_q;
    wb_d   = wb_adv ? IDXW'(stq_pkg::ring_add(int'(wb_q), 1, 0, SLOTS)) : wb_q;
    tail_d = IDXW'(stq_pkg::ring_add(int'(tail_q), int'(ins_ok), int'(kill_cnt), SLOTS));
    occ_d  = occ_q + CNTW'(ins_ok) - CNTW'(retire) - kill_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      wb_q   <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= head_d;
      wb_q   <= wb_d;
      tail_q <= tail_d;
      occ_q  <= occ_d;
    end
  end

endmodule

// File: rtl/stq_wbport.sv
module stq_wbport #(
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ent_ready,
  input  logic            mreq_ready,
  input  logic            mretry,
  input  logic [CNTW-1:0] new_cnt,
  output logic            req_valid,
  output logic            accept,
  output logic [CNTW-1:0] pend_q
);

  logic            blk_q, blk_d;
  logic [CNTW-1:0] pend_d;

  always_comb begin
    req_valid = ent_ready && !blk_q;
    accept    = req_valid && mreq_ready;
    // Once refused, stay silent until the memory side signals a retry.
    blk_d     = blk_q ? !mretry : (req_valid && !mreq_ready);
    pend_d    = pend_q + new_cnt - CNTW'(accept);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= 1'b0;
      pend_q <= '0;
    end else begin
      blk_q  <= blk_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/stq_store_queue.sv
module stq_store_queue #(
  parameter int SLOTS = 8,
  parameter int TAGW  = 16,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int SZW   = 4,
  localparam int IDXW = $clog2(SLOTS),
  localparam int CNTW = $clog2(SLOTS) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_valid,
  input  logic [TAGW-1:0] ins_tag,
  output logic [IDXW-1:0] ins_idx,
  input  logic            dw_valid,
  input  logic [IDXW-1:0] dw_idx,
  input  logic [AW-1:0]   dw_addr,
  input  logic [SZW-1:0]  dw_size,
  input  logic [DW-1:0]   dw_data,
  input  logic            cm_valid,
  input  logic [TAGW-1:0] cm_tag,
  input  logic            sq_valid,
  input  logic [TAGW-1:0] sq_tag,
  output logic            mreq_valid,
  input  logic            mreq_ready,
  output logic [IDXW-1:0] mreq_idx,
  output logic [AW-1:0]   mreq_addr,
  output logic [SZW-1:0]  mreq_size,
  output logic [DW-1:0]   mreq_data,
  input  logic            mretry,
  input  logic            mack_valid,
  input  logic [IDXW-1:0] mack_idx,
  output logic [CNTW-1:0] occ,
  output logic            full,
  output logic [CNTW-1:0] wb_pending
);

  logic [IDXW-1:0]  head_q, wb_q, tail_q;
  logic [CNTW-1:0]  occ_q, kill_cnt, new_cnt;
  logic [SLOTS-1:0] occ_mask, cwb_v, cmp_v, newc_mask, kill_mask;
  logic             ins_ok, retire, ent_ready, accept;

  // A slot is live when its distance from the head is below the occupancy.
  for (genvar i = 0; i < SLOTS; i++) begin : g_live
    assign occ_mask[i] = CNTW'(stq_pkg::ring_dist(int'(head_q), i, SLOTS)) < occ_q;
  end

  assign full      = occ_q >= CNTW'(SLOTS - 1);
  assign ins_ok    = ins_valid && !full && !sq_valid;
  assign retire    = (occ_q != '0) && cmp_v[head_q];
  assign ent_ready = (wb_q != tail_q) && cwb_v[wb_q] && !cmp_v[wb_q];

  always_comb begin
    kill_cnt = '0;
    new_cnt  = '0;
    for (int k = 0; k < SLOTS; k++) begin
      kill_cnt = kill_cnt + CNTW'(kill_mask[k]);
      new_cnt  = new_cnt + CNTW'(newc_mask[k]);
    end
  end

  stq_entries #(
    .SLOTS(SLOTS), .IDXW(IDXW), .TAGW(TAGW), .AW(AW), .DW(DW), .SZW(SZW)
  ) u_entries (
    .clk       (clk),
    .rst_n     (rst_n),
    .occ_mask  (occ_mask),
    .ins_en    (ins_ok),
    .tail_idx  (tail_q),
    .ins_tag   (ins_tag),
    .dw_valid  (dw_valid),
    .dw_idx    (dw_idx),
    .dw_addr   (dw_addr),
    .dw_size   (dw_size),
    .dw_data   (dw_data),
    .cm_valid  (cm_valid),
    .cm_tag    (cm_tag),
    .sq_valid  (sq_valid),
    .sq_tag    (sq_tag),
    .ack_valid (mack_valid),
    .ack_idx   (mack_idx),
    .rd_idx    (wb_q),
    .rd_addr   (mreq_addr),
    .rd_size   (mreq_size),
    .rd_data   (mreq_data),
    .cwb_v     (cwb_v),
    .cmp_v     (cmp_v),
    .newc_mask (newc_mask),
    .kill_mask (kill_mask)
  );

  stq_ptrs #(
    .SLOTS(SLOTS), .IDXW(IDXW), .CNTW(CNTW)
  ) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_ok   (ins_ok),
    .retire   (retire),
    .wb_adv   (accept),
    .kill_cnt (kill_cnt),
    .head_q   (head_q),
    .wb_q     (wb_q),
    .tail_q   (tail_q),
    .occ_q    (occ_q)
  );

  stq_wbport #(
    .CNTW(CNTW)
  ) u_wbport (
    .clk        (clk),
    .rst_n      (rst_n),
    .ent_ready  (ent_ready),
    .mreq_ready (mreq_ready),
    .mretry     (mretry),
    .new_cnt    (new_cnt),
    .req_valid  (mreq_valid),
    .accept     (accept),
    .pend_q     (wb_pending)
  );

  assign ins_idx  = tail_q;
  assign mreq_idx = wb_q;
  assign occ      = occ_q;

endmodule

// File: rtl/stq_chk.sv
module stq_chk #(
  parameter int SLOTS = 8,
  parameter int IDXW  = 3,
  parameter int CNTW  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sq_valid,
  input logic            mreq_valid,
  input logic            mreq_ready,
  input logic [IDXW-1:0] mreq_idx,
  input logic [CNTW-1:0] occ,
  input logic            full,
  input logic [CNTW-1:0] wb_pending
);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNTW'(SLOTS - 1));

  a_r3_full_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> occ <= $past(occ));

  a_r8_refusal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> !mreq_valid);

  a_r8_same_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> mreq_idx == $past(mreq_idx));

  a_r10_insert_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> occ <= $past(occ));

  a_r9_one_release: assert property (@(posedge clk) disable iff (!rst_n)
    !sq_valid |=> ({1'b0, occ} + 1'b1) >= {1'b0, $past(occ)});

  a_r11_pending_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pending <= occ);

endmodule

bind stq_store_queue stq_chk #(
  .SLOTS(SLOTS), .IDXW(IDXW), .CNTW(CNTW)
) u_stq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sq_valid   (sq_valid),
  .mreq_valid (mreq_valid),
  .mreq_ready (mreq_ready),
  .mreq_idx   (mreq_idx),
  .occ        (occ),
  .full       (full),
  .wb_pending (wb_pending)
);

// File: tb/stq_store_queue_bench.sv
module stq_store_queue_bench;
  localparam int SLOTS = 8;
  localparam int TAGW  = 16;
  localparam int AW    = 32;
  localparam int DW    = 64;
  localparam int SZW   = 4;
  localparam int IDXW  = $clog2(SLOTS);
  localparam int CNTW  = $clog2(SLOTS) + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ins_valid = 1'b0;
  logic [TAGW-1:0] ins_tag = '0;
  logic [IDXW-1:0] ins_idx;
  logic            dw_valid = 1'b0;
  logic [IDXW-1:0] dw_idx = '0;
  logic [AW-1:0]   dw_addr = '0;
  logic [SZW-1:0]  dw_size = '0;
  logic [DW-1:0]   dw_data = '0;
  logic            cm_valid = 1'b0;
  logic [TAGW-1:0] cm_tag = '0;
  logic            sq_valid = 1'b0;
  logic [TAGW-1:0] sq_tag = '0;
  logic            mreq_valid;
  logic            mreq_ready = 1'b0;
  logic [IDXW-1:0] mreq_idx;
  logic [AW-1:0]   mreq_addr;
  logic [SZW-1:0]  mreq_size;
  logic [DW-1:0]   mreq_data;
  logic            mretry = 1'b0;
  logic            mack_valid = 1'b0;
  logic [IDXW-1:0] mack_idx = '0;
  logic [CNTW-1:0] occ;
  logic            full;
  logic [CNTW-1:0] wb_pending;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  bit mon_on = 1'b0;

  always #4 clk = ~clk;

  stq_store_queue u_stq_store_queue (.*);

  // Reference state, advanced once per cycle just before each rising edge.
  int          m_tag  [SLOTS];
  logic [31:0] m_addr [SLOTS];
  int          m_size [SLOTS];
  logic [63:0] m_data [SLOTS];
  bit          m_cmt  [SLOTS];
  bit          m_cmp  [SLOTS];
  int mhead = 0, mwb = 0, mtail = 0, mocc = 0, mpend = 0;
  bit mblk = 1'b0;

  function automatic int mdist(input int a, input int b);
    return (b + SLOTS - a) % SLOTS;
  endfunction

  function automatic bit m_live(input int i);
    return mdist(mhead, i) < mocc;
  endfunction

  function automatic bit m_reqv();
    return (mwb != mtail) && m_cmt[mwb] && !m_cmp[mwb] && !mblk;
  endfunction

  task automatic check(input string rq, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic model_compare();
    bit rv;
    rv = m_reqv();
    check("R9", "occ", longint'(occ), longint'(mocc));
    check("R3", "full", longint'(full), longint'(mocc >= SLOTS - 1));
    check("R6", "wb_pending", longint'(wb_pending), longint'(mpend));
    check("R2", "ins_idx", longint'(ins_idx), longint'(mtail));
    check("R7", "mreq_valid", longint'(mreq_valid), longint'(rv));
    if (rv) begin
      check("R7", "mreq_idx", longint'(mreq_idx), longint'(mwb));
      check("R5", "mreq_addr", longint'(mreq_addr), longint'(m_addr[mwb]));
      check("R5", "mreq_size", longint'(mreq_size), longint'(m_size[mwb]));
      check("R5", "mreq_data", longint'(mreq_data), longint'(m_data[mwb]));
    end
  endtask

  task automatic model_step();
    bit rv, ret, acc, ins_ok;
    bit live [SLOTS];
    bit cmh  [SLOTS];
    bit kl   [SLOTS];
    int kills;
    rv     = m_reqv();
    ret    = (mocc > 0) && m_cmp[mhead];
    acc    = rv && mreq_ready;
    ins_ok = ins_valid && !(mocc >= SLOTS - 1) && !sq_valid;
    kills  = 0;
    for (int i = 0; i < SLOTS; i++) begin
      live[i] = m_live(i);
      cmh[i]  = cm_valid && live[i] && !m_cmt[i] && (m_tag[i] <= int'(cm_tag));
      kl[i]   = sq_valid && live[i] && !m_cmt[i] && !cmh[i] && (m_tag[i] > int'(sq_tag));
    end
    for (int i = 0; i < SLOTS; i++) begin
      if (kl[i]) kills++;
      if (cmh[i]) begin
        m_cmt[i] = 1'b1;
        mpend++;
      end
      if (dw_valid && live[i] && int'(dw_idx) == i) begin
        m_addr[i] = dw_addr;
        m_size[i] = int'(dw_size);
        m_data[i] = dw_data;
      end
      if (mack_valid && live[i] && int'(mack_idx) == i) m_cmp[i] = 1'b1;
    end
    if (acc) begin
      mwb = (mwb + 1) % SLOTS;
      mpend--;
    end
    mblk = mblk ? !mretry : (rv && !mreq_ready);
    if (ins_ok) begin
      m_tag[mtail]  = int'(ins_tag);
      m_size[mtail] = 0;
      m_cmt[mtail]  = 1'b0;
      m_cmp[mtail]  = 1'b0;
    end
    if (ret) mhead = (mhead + 1) % SLOTS;
    mtail = (mtail + int'(ins_ok) + SLOTS - kills) % SLOTS;
    mocc  = mocc + int'(ins_ok) - int'(ret) - kills;
  endtask

  // Sample one time unit before each rising edge, then advance the model.
  always @(negedge clk) begin
    #3;
    if (rst_n && mon_on && !finished) begin
      model_compare();
      model_step();
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
    ins_valid  = 1'b0;
    dw_valid   = 1'b0;
    cm_valid   = 1'b0;
    sq_valid   = 1'b0;
    mretry     = 1'b0;
    mack_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL R1 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int next_tag;
    int seed;
    seed = int'($urandom(32'd20240611));
    for (int i = 0; i < SLOTS; i++) begin
      m_tag[i] = 0; m_addr[i] = '0; m_size[i] = 0; m_data[i] = '0;
      m_cmt[i] = 1'b0; m_cmp[i] = 1'b0;
    end
    idle(3);
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle(2);

    // R1: reset state
    check("R1", "occ", longint'(occ), 0);
    check("R1", "full", longint'(full), 0);
    check("R1", "wb_pending", longint'(wb_pending), 0);
    check("R1", "mreq_valid", longint'(mreq_valid), 0);

    // R2/R3: fill all usable slots, then offer one more while full
    for (int t = 1; t <= 8; t++) begin
      ins_valid = 1'b1;
      ins_tag   = TAGW'(t);
      step();
    end
    check("R3", "occ when full", longint'(occ), SLOTS - 1);
    check("R3", "full", longint'(full), 1);
    check("R2", "ins_idx after fill", longint'(ins_idx), SLOTS - 1);

    // R5: data-writes to slots 1..6; slot 0 stays unwritten
    for (int s = 1; s <= 6; s++) begin
      dw_valid = 1'b1;
      dw_idx   = IDXW'(s);
      dw_addr  = 32'h1000 + 32'(s * 8);
      dw_size  = 4'd8;
      dw_data  = 64'hA5A5_0000_0000_0000 + 64'(s);
      step();
    end

    // R4/R6: commit the unwritten oldest store with memory not ready
    mreq_ready = 1'b0;
    cm_valid = 1'b1; cm_tag = 16'd1;
    step();
    check("R4", "mreq_valid", longint'(mreq_valid), 1);
    check("R4", "mreq_idx", longint'(mreq_idx), 0);
    check("R4", "mreq_size unwritten", longint'(mreq_size), 0);
    check("R6", "wb_pending", longint'(wb_pending), 1);

    // R8: refusal blocks until retry
    step();
    check("R8", "silent after refusal", longint'(mreq_valid), 0);
    idle(2);
    check("R8", "still silent", longint'(mreq_valid), 0);
    mretry = 1'b1;
    step();
    check("R8", "reoffered", longint'(mreq_valid), 1);
    check("R8", "same slot", longint'(mreq_idx), 0);
    mreq_ready = 1'b1;
    step();
    check("R11", "wb_pending after accept", longint'(wb_pending), 0);
    check("R9", "occ not freed at issue", longint'(occ), SLOTS - 1);

    // R6/R7/R5: commit two more, observe in-order offers
    cm_valid = 1'b1; cm_tag = 16'd3;
    step();
    check("R6", "wb_pending two", longint'(wb_pending), 2);
    check("R7", "next slot", longint'(mreq_idx), 1);
    check("R5", "addr slot1", longint'(mreq_addr), 32'h1008);
    check("R5", "data slot1", longint'(mreq_data), 64'hA5A5_0000_0000_0001);
    cm_valid = 1'b1; cm_tag = 16'd2;
    step();
    check("R6", "recommit adds nothing", longint'(wb_pending), 1);
    idle(2);
    check("R11", "drained", longint'(wb_pending), 0);

    // R9: out-of-order completion
    mack_valid = 1'b1; mack_idx = 3'd2;
    step();
    idle(3);
    check("R9", "head waits on slot0", longint'(occ), SLOTS - 1);
    mack_valid = 1'b1; mack_idx = 3'd0;
    step();
    idle(3);
    check("R9", "one released", longint'(occ), SLOTS - 2);
    mack_valid = 1'b1; mack_idx = 3'd1;
    step();
    idle(4);
    check("R9", "contiguous released", longint'(occ), 4);

    // R10: squash younger uncommitted, same-cycle insert dropped
    sq_valid = 1'b1; sq_tag = 16'd4;
    ins_valid = 1'b1; ins_tag = 16'd9;
    step();
    check("R10", "occ after squash", longint'(occ), 1);
    check("R10", "tail rewound", longint'(ins_idx), 4);
    cm_valid = 1'b1; cm_tag = 16'd4;
    step();
    sq_valid = 1'b1; sq_tag = 16'd0;
    step();
    check("R10", "committed survives", longint'(occ), 1);
    idle(2);
    mack_valid = 1'b1; mack_idx = 3'd3;
    step();
    idle(3);
    check("R9", "empty", longint'(occ), 0);
    check("R3", "not full", longint'(full), 0);

    // Constrained random phase
    next_tag = 20;
    for (int c = 0; c < 5000; c++) begin
      mreq_ready = ($urandom % 10) < 8;
      if (($urandom % 10) < 4) begin
        ins_valid = 1'b1;
        ins_tag   = TAGW'(next_tag);
        next_tag++;
      end
      if (($urandom % 10) < 3) begin
        dw_valid = 1'b1;
        dw_idx   = IDXW'($urandom % SLOTS);
        dw_addr  = $urandom;
        dw_size  = SZW'(1 << ($urandom % 4));
        dw_data  = {$urandom, $urandom};
      end
      if (($urandom % 100) < 15) begin
        cm_valid = 1'b1;
        cm_tag   = TAGW'(next_tag - 1 - int'($urandom % 6));
      end
      if (($urandom % 100) < 3) begin
        sq_valid = 1'b1;
        sq_tag   = TAGW'(next_tag - 1 - int'($urandom % 5));
      end
      if (mblk && ($urandom % 2) == 1) mretry = 1'b1;
      if (($urandom % 10) < 4) begin
        int issued, pick;
        issued = mdist(mhead, mwb);
        if (mocc > 0 && issued > 0) begin
          pick = (mhead + int'($urandom % issued)) % SLOTS;
          if (!m_cmp[pick]) begin
            mack_valid = 1'b1;
            mack_idx   = IDXW'(pick);
          end
        end
      end
      step();
    end

    idle(2);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule